// File: doc/BRIEF.md
# Address Generation Unit with Circular and Bit-Reversed Modes

This block forms the data-memory addresses for a DSP datapath. It keeps eight pointer registers, each paired by index with an offset register and a modifier register. On every access request the block returns an effective address in the same cycle. When the access form calls for it, the block also writes an updated pointer back on the next clock edge.

The modifier register paired with a pointer selects how that pointer moves:

- **Plain two's-complement arithmetic.** The pointer wraps at 2^16.
- **Circular-buffer arithmetic.** A modulo-M buffer sits at a base aligned to the next power of two.
- **Reverse-carry arithmetic.** The carry runs from the top bit downward, so FFT data can be walked in bit-reversed order.

An instruction decoder drives the request port. Configuration code loads the three register banks through a single write port.

Top module: `agu_top`

## Requirements
- R1: After synchronous reset every pointer and offset register holds 0 and every modifier register holds 0xFFFF, so all pointers start in plain linear arithmetic.
- R2: A write with `wr_en` high stores `wr_data` at the next edge into the bank chosen by `wr_bank`: 0 = pointer, 1 = offset, 2 = modifier. Bank code 3 changes nothing. When a pointer write and a pointer update target the same index in the same cycle, the written value wins.
- R3: `req_mode` codes are: 0 post +1, 1 post −1, 2 post +offset, 3 post −offset, 4 indexed by offset, 5 pre-decrement, 6 and 7 plain (no update). For codes 0–3 and 6–7, `ea` equals the current pointer value in the request cycle. For codes 0–3 the moved value is committed at the next edge.
- R4: Indexed mode (code 4) gives `ea` = pointer + offset under that pointer's arithmetic, and the pointer is left unchanged.
- R5: Pre-decrement (code 5) gives `ea` = pointer − 1 under that pointer's arithmetic, in the request cycle, and commits that same value to the pointer at the next edge.
- R6: A modifier of 0xFFFF, or any value from 0x8000 to 0xFFFE, selects linear arithmetic modulo 2^16.
- R7: A modifier value M−1 in the range 1 to 0x7FFF selects modulo-M arithmetic. The base is the pointer with the bits below the next power of two at or above M cleared. A result past base+M−1 has M subtracted, and a result below the base has M added. Step sizes are at most M.
- R8: A modifier of 0 selects reverse-carry arithmetic: the result is rev(rev(pointer) ± rev(step)), where rev mirrors the 16 bits.
- R9: A pointer never changes without a request of code 0, 1, 2, 3 or 5, or a pointer write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Bank select: 0 pointer, 1 offset, 2 modifier, 3 none |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 16 | Write data |
| req_valid | input | 1 | Access request strobe |
| req_idx | input | 3 | Pointer index for the access |
| req_mode | input | 3 | Access form code (see R3) |
| ea | output | 16 | Effective address, combinational in the request cycle |

## Verification
The effective address is due in the same cycle as its request. The bench drives each request just after a falling edge and samples `ea` one time unit later, well before the rising edge that commits the pointer. Register updates and writes become visible one edge later. The bench observes them with a plain-mode request (code 6) in a later cycle, so it never reads a value inside the cycle where it changes. A reference model applies each write and update at the same point in time as the design.

// File: rtl/agu_pkg.sv
package agu_pkg;

    parameter int ADDR_W = 16;
    parameter int NREG   = 8;
    localparam int IDX_W = $clog2(NREG);
    localparam int EXT_W = ADDR_W + 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  ridx_t;

    typedef enum logic [2:0] {
        AM_POST_INC  = 3'd0,
        AM_POST_DEC  = 3'd1,
        AM_POST_ADDN = 3'd2,
        AM_POST_SUBN = 3'd3,
        AM_INDEX     = 3'd4,
        AM_PRE_DEC   = 3'd5,
        AM_PLAIN     = 3'd6,
        AM_PLAIN_ALT = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        WB_ADDR = 2'd0,
        WB_OFFS = 2'd1,
        WB_MODF = 2'd2,
        WB_NONE = 2'd3
    } wbank_e;

    typedef enum logic [1:0] {
        AR_LINEAR  = 2'd0,
        AR_MODULO  = 2'd1,
        AR_REVERSE = 2'd2
    } arith_e;

    typedef struct packed {
        addr_t mag;     // step magnitude
        logic  neg;     // subtract when set
        logic  commit;  // write result back to the pointer
        logic  ea_new;  // effective address is the moved value
    } step_t;

    function automatic addr_t bit_rev(input addr_t v);
        addr_t r;
        for (int i = 0; i < ADDR_W; i++) r[i] = v[ADDR_W-1-i];
        return r;
    endfunction

    // Ones at and below the highest set bit of v.
    function automatic addr_t low_smear(input addr_t v);
        addr_t m;
        m[ADDR_W-1] = v[ADDR_W-1];
        for (int i = ADDR_W-2; i >= 0; i--) m[i] = m[i+1] | v[i];
        return m;
    endfunction

    function automatic arith_e classify(input addr_t modf);
        if (modf == '0)              return AR_REVERSE;
        else if (modf[ADDR_W-1] == 1'b0) return AR_MODULO;
        else                         return AR_LINEAR;
    endfunction

endpackage

// File: rtl/agu_regfile.sv
module agu_regfile
    import agu_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [1:0]             wr_bank,
    input  ridx_t                  wr_idx,
    input  addr_t                  wr_data,
    input  logic                   upd_en,
    input  ridx_t                  upd_idx,
    input  addr_t                  upd_val,
    output logic [NREG-1:0][ADDR_W-1:0] areg_q,
    output logic [NREG-1:0][ADDR_W-1:0] oreg_q,
    output logic [NREG-1:0][ADDR_W-1:0] mreg_q
);

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        logic hit_w;
        logic hit_u;
        assign hit_w = wr_en && (wr_idx == ridx_t'(g));
        assign hit_u = upd_en && (upd_idx == ridx_t'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                areg_q[g] <= '0;
                oreg_q[g] <= '0;
                mreg_q[g] <= '1;
            end else begin
                if (hit_w && wbank_e'(wr_bank) == WB_ADDR) areg_q[g] <= wr_data;
                else if (hit_u)                            areg_q[g] <= upd_val;
                if (hit_w && wbank_e'(wr_bank) == WB_OFFS) oreg_q[g] <= wr_data;
                if (hit_w && wbank_e'(wr_bank) == WB_MODF) mreg_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/agu_step_decode.sv
module agu_step_decode
    import agu_pkg::*;
(
    input  logic [2:0] mode,
    input  addr_t      offs,
    output step_t      step
);

    always_comb begin
        step = '{mag: addr_t'(1), neg: 1'b0, commit: 1'b0, ea_new: 1'b0};
        unique case (amode_e'(mode))
            AM_POST_INC:  step.commit = 1'b1;
            AM_POST_DEC:  begin step.neg = 1'b1; step.commit = 1'b1; end
            AM_POST_ADDN: begin step.mag = offs; step.commit = 1'b1; end
            AM_POST_SUBN: begin step.mag = offs; step.neg = 1'b1; step.commit = 1'b1; end
            AM_INDEX:     begin step.mag = offs; step.ea_new = 1'b1; end
            AM_PRE_DEC:   begin step.neg = 1'b1; step.commit = 1'b1; step.ea_new = 1'b1; end
            AM_PLAIN, AM_PLAIN_ALT: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/agu_arith.sv
module agu_arith
    import agu_pkg::*;
(
    input  addr_t addr,
    input  addr_t mag,
    input  logic  neg,
    input  addr_t modf,
    output addr_t res
);

    arith_e kind;
    addr_t  lin_res, rev_res, mod_res;

    assign kind = classify(modf);

    // Linear
    assign lin_res = neg ? addr - mag : addr + mag;

    // Reverse carry: add in mirrored bit order
    addr_t rr, rs, rsum;
    assign rr      = bit_rev(addr);
    assign rs      = bit_rev(mag);
    assign rsum    = neg ? rr - rs : rr + rs;
    assign rev_res = bit_rev(rsum);

    // Modulo
    addr_t mask, base;
    logic signed [EXT_W-1:0] msize, off, t0, t1;
    assign mask  = low_smear(modf);
    assign base  = addr & ~mask;
    assign msize = EXT_W'({1'b0, modf}) + EXT_W'(1);
    assign off   = EXT_W'(addr & mask);
    assign t0    = neg ? off - EXT_W'(mag) : off + EXT_W'(mag);

    always_comb begin
        if (t0 < 0)           t1 = t0 + msize;
        else if (t0 >= msize) t1 = t0 - msize;
        else                  t1 = t0;
    end
    assign mod_res = base | (t1[ADDR_W-1:0] & mask);

    always_comb begin
        unique case (kind)
            AR_MODULO:  res = mod_res;
            AR_REVERSE: res = rev_res;
            default:    res = lin_res;
        endcase
    end

endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [1:0]              wr_bank,
    input  logic [agu_pkg::IDX_W-1:0]  wr_idx,
    input  logic [agu_pkg::ADDR_W-1:0] wr_data,
    input  logic                    req_valid,
    input  logic [agu_pkg::IDX_W-1:0]  req_idx,
    input  logic [2:0]              req_mode,
    output logic [agu_pkg::ADDR_W-1:0] ea
);

    logic [NREG-1:0][ADDR_W-1:0] areg_q, oreg_q, mreg_q;
    addr_t cur_a, cur_n, cur_m, moved;
    step_t step;
    logic  upd_en;

    assign cur_a = areg_q[req_idx];
    assign cur_n = oreg_q[req_idx];
    assign cur_m = mreg_q[req_idx];

    agu_step_decode dec_i (
        .mode (req_mode),
        .offs (cur_n),
        .step (step)
    );

    agu_arith arith_i (
        .addr (cur_a),
        .mag  (step.mag),
        .neg  (step.neg),
        .modf (cur_m),
        .res  (moved)
    );

    assign upd_en = req_valid && step.commit;
    assign ea     = step.ea_new ? moved : cur_a;

    agu_regfile rf_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .upd_en  (upd_en),
        .upd_idx (req_idx),
        .upd_val (moved),
        .areg_q  (areg_q),
        .oreg_q  (oreg_q),
        .mreg_q  (mreg_q)
    );

endmodule

// File: rtl/agu_checker.sv
module agu_checker
    import agu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_bank,
    input ridx_t       wr_idx,
    input addr_t       wr_data,
    input logic        req_valid,
    input ridx_t       req_idx,
    input logic [2:0]  req_mode,
    input addr_t       ea,
    input logic [NREG-1:0][ADDR_W-1:0] areg,
    input logic [NREG-1:0][ADDR_W-1:0] mreg
);

    logic no_wr;
    assign no_wr = !wr_en || (wr_bank != 2'd0);

    // R9: no request and no pointer write keeps all pointers
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && no_wr) |=> $stable(areg));

    // R4: indexed access leaves pointers untouched
    p_index_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'd4 && no_wr) |=> $stable(areg));

    // R3: post forms and plain present the pointer itself
    p_post_ea_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_mode <= 3'd3 || req_mode >= 3'd6)) |-> ea == areg[req_idx]);

    // R5: pre-decrement commits the address it presented
    p_predec_commit_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'd5 && no_wr) |=> areg[$past(req_idx)] == $past(ea));

    // R2: pointer write wins
    p_write_wins_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_bank == 2'd0) |=> areg[$past(wr_idx)] == $past(wr_data));

    // R6: linear post-increment
    p_linear_inc_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'd0 && no_wr && mreg[req_idx] == '1)
        |=> areg[$past(req_idx)] == $past(areg[req_idx]) + addr_t'(1));

endmodule

bind agu_top agu_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_bank   (wr_bank),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .req_mode  (req_mode),
    .ea        (ea),
    .areg      (areg_q),
    .mreg      (mreg_q)
);

// File: tb/agu_top_tb.sv
module agu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_bank;
    logic [2:0]  wr_idx;
    logic [15:0] wr_data;
    logic        req_valid;
    logic [2:0]  req_idx;
    logic [2:0]  req_mode;
    logic [15:0] ea;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] ma [8];
    logic [15:0] mn [8];
    logic [15:0] mm [8];

    always #4 clk = ~clk;

    agu_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
        .wr_data(wr_data), .req_valid(req_valid), .req_idx(req_idx),
        .req_mode(req_mode), .ea(ea)
    );

    function automatic logic [15:0] rv(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    // Reference arithmetic built from the requirements
    function automatic logic [15:0] ref_move(input logic [15:0] a, input logic [15:0] s,
                                             input bit neg, input logic [15:0] m);
        int msz, p, base, off, t;
        if (m == 16'h0) begin
            return neg ? rv(rv(a) - rv(s)) : rv(rv(a) + rv(s));
        end else if (m < 16'h8000) begin
            msz = int'(m) + 1;
            p = 1;
            while (p < msz) p = p * 2;
            base = int'(a) & ~(p - 1);
            off  = int'(a) - base;
            t    = neg ? off - int'(s) : off + int'(s);
            t    = ((t % msz) + msz) % msz;
            return 16'(base + t);
        end else begin
            return neg ? a - s : a + s;
        end
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] bank, input int idx, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_bank = bank; wr_idx = 3'(idx); wr_data = d; req_valid = 0;
        case (bank)
            2'd0: ma[idx] = d;
            2'd1: mn[idx] = d;
            2'd2: mm[idx] = d;
            default: ;
        endcase
    endtask

    // One access; optional simultaneous pointer write to the same index
    task automatic access(input int idx, input int mode, input string tag,
                          input bit with_wr = 0, input logic [15:0] wd = 16'h0);
        logic [15:0] exp_ea, nv;
        bit commit;
        @(negedge clk);
        wr_en = with_wr; wr_bank = 2'd0; wr_idx = 3'(idx); wr_data = wd;
        req_valid = 1; req_idx = 3'(idx); req_mode = 3'(mode);
        commit = 0;
        nv = ma[idx];
        case (mode)
            0: begin nv = ref_move(ma[idx], 16'd1, 0, mm[idx]); commit = 1; exp_ea = ma[idx]; end
            1: begin nv = ref_move(ma[idx], 16'd1, 1, mm[idx]); commit = 1; exp_ea = ma[idx]; end
            2: begin nv = ref_move(ma[idx], mn[idx], 0, mm[idx]); commit = 1; exp_ea = ma[idx]; end
            3: begin nv = ref_move(ma[idx], mn[idx], 1, mm[idx]); commit = 1; exp_ea = ma[idx]; end
            4: exp_ea = ref_move(ma[idx], mn[idx], 0, mm[idx]);
            5: begin nv = ref_move(ma[idx], 16'd1, 1, mm[idx]); commit = 1; exp_ea = nv; end
            default: exp_ea = ma[idx];
        endcase
        #1;
        check(tag, ea, exp_ea);
        if (with_wr) ma[idx] = wd;
        else if (commit) ma[idx] = nv;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 0; req_valid = 0;
    endtask

    task automatic readback(input int idx, input string tag);
        access(idx, 6, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; wr_en = 0; wr_bank = 0; wr_idx = 0; wr_data = 0;
        req_valid = 0; req_idx = 0; req_mode = 0;
        for (int i = 0; i < 8; i++) begin ma[i] = 0; mn[i] = 0; mm[i] = 16'hFFFF; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset values; offset 0 via indexed, linear via post +1
        for (int i = 0; i < 8; i++) begin
            readback(i, "R1 pointer reset");
            access(i, 4, "R1 offset reset");
            access(i, 0, "R1 linear modifier at reset");
            readback(i, "R1 post-inc after reset");
        end

        // R6: linear wrap at 2^16, reserved modifier also linear
        write_reg(2'd0, 1, 16'hFFFF);
        access(1, 0, "R6 linear wrap up");
        readback(1, "R6 linear wrap result");
        write_reg(2'd2, 1, 16'h9000);
        write_reg(2'd1, 1, 16'h0010);
        access(1, 3, "R6 reserved modifier subtract");
        readback(1, "R6 reserved modifier result");

        // R7: modulo 5 buffer at 0x0100
        write_reg(2'd2, 2, 16'd4);
        write_reg(2'd0, 2, 16'h0104);
        access(2, 0, "R7 modulo upper wrap");
        readback(2, "R7 modulo wrapped to base");
        access(2, 1, "R7 modulo lower step");
        readback(2, "R7 modulo wrapped to top");
        write_reg(2'd1, 2, 16'd3);
        write_reg(2'd0, 2, 16'h0103);
        access(2, 2, "R7 modulo offset wrap");
        readback(2, "R7 modulo offset result");

        // R8: reverse carry walk, step 8 for 16-point FFT
        write_reg(2'd2, 3, 16'h0000);
        write_reg(2'd1, 3, 16'h0008);
        write_reg(2'd0, 3, 16'h0000);
        for (int k = 0; k < 6; k++) access(3, 2, "R8 reverse carry walk");
        readback(3, "R8 reverse carry pointer");
        access(3, 1, "R8 reverse carry minus one");
        readback(3, "R8 reverse carry minus result");

        // R4: indexed leaves pointer
        write_reg(2'd1, 4, 16'h0020);
        write_reg(2'd0, 4, 16'h1234);
        access(4, 4, "R4 indexed address");
        readback(4, "R4 pointer unchanged");

        // R5: pre-decrement
        access(4, 5, "R5 pre-decrement address");
        readback(4, "R5 pointer committed");

        // R2: write wins over update; bank 3 ignored
        access(5, 0, "R2 access with write", 1, 16'hBEEF);
        readback(5, "R2 write wins");
        write_reg(2'd3, 5, 16'h7777);
        readback(5, "R2 bank 3 pointer unchanged");
        access(5, 4, "R2 bank 3 offset unchanged");

        // R9: idle cycles and plain code 7 leave pointers
        idle(); idle();
        access(5, 7, "R9 plain alt code");
        readback(5, "R9 no update without request");

        // R3 R6 R7 R8: random configurations and accesses
        for (int round = 0; round < 4; round++) begin
            for (int i = 0; i < 8; i++) begin
                int kind, msz, p;
                logic [15:0] base;
                kind = $urandom % 3;
                if (kind == 0) begin
                    write_reg(2'd2, i, ($urandom % 2) ? 16'hFFFF : 16'(16'h8000 | ($urandom % 16'h7FFF)));
                    write_reg(2'd1, i, 16'($urandom));
                    write_reg(2'd0, i, 16'($urandom));
                end else if (kind == 1) begin
                    msz = 2 + $urandom % 60;
                    p = 1;
                    while (p < msz) p = p * 2;
                    base = 16'($urandom) & ~16'(p - 1);
                    write_reg(2'd2, i, 16'(msz - 1));
                    write_reg(2'd1, i, 16'($urandom % (msz + 1)));
                    write_reg(2'd0, i, base + 16'($urandom % msz));
                end else begin
                    write_reg(2'd2, i, 16'h0000);
                    write_reg(2'd1, i, 16'($urandom));
                    write_reg(2'd0, i, 16'($urandom));
                end
            end
            for (int k = 0; k < 300; k++)
                access($urandom % 8, $urandom % 8, "R3 random access");
        end

        idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule